// File: doc/BRIEF.md
# Stream Descriptor List Walker

This block drives one audio stream through a circular list of buffer descriptors held in memory. A register block supplies a run bit, a stream reset bit, the list base address and the last valid index. Each time the walker enters a list entry it fetches that entry's descriptor over a valid/ready read port. It then serves one 32-bit sample word per request from the sample side, reading or writing the word at the current place in the entry's buffer through a memory port.

The walker keeps a link position: a count of bytes moved since the stream started or since the list last wrapped. It presents this count on a register output and on an alias output. When the position buffer is enabled, it also writes the count to a per-stream slot in memory. If a descriptor's completion flag is set, the buffer-complete status bit is set when that entry finishes. The bit stays set until software clears it.

Top module: `stream_desc_walker`

## Requirements
- R1: After reset the walker is stopped (`running` 0). `linkPos`, `linkPosAlias`, `bufComplete` and `fifoReady` are 0, and no descriptor request, memory request or position write is driven.
- R2: A rising edge of `ctrlRun` while stopped starts the stream. The entry index, the byte offset and `linkPos` are cleared, and the first descriptor is requested at `listBase`. In general, entry i is requested at `listBase + 16*i`. The descriptor data uses these bit positions: [63:0] buffer address, [95:64] byte length (a nonzero multiple of 4), and [96] completion flag. The list holds `lastIdx + 1` entries, at most `MAX_ENTRIES`.
- R3: Each accepted word accesses `memAddr` = buffer address + byte offset. `xferDir` 1 reads memory and returns the word on `xferRdata`; `xferDir` 0 writes `xferWdata`. `xferDone` is high in the cycle `memAck` is seen. On that edge the byte offset and `linkPos` each advance by 4.
- R4: When the offset reaches the entry length, the offset returns to 0, the index advances, and the next descriptor is fetched before any further word is served.
- R5: Finishing entry `lastIdx` wraps the index to 0 and sets `linkPos` to 0.
- R6: Finishing an entry whose completion flag is set sets `bufComplete`. An entry without the flag leaves the bit unchanged. A pulse on `stsClear` clears it.
- R7: `linkPosAlias` always carries the same value as `linkPos`.
- R8: With `posBufEn` high, `posWrEn` pulses in the cycle after each change of `linkPos` (start and every word). It writes the new position to `posBufBase + 8*STREAM_SLOT`. With `posBufEn` low, there are no position writes.
- R9: A request on `xferValid` while stopped is refused: `xferErr` is high in the same cycle, no memory access is made, and `linkPos` does not change.
- R10: When `ctrlRun` falls, the walker stops once no memory access is outstanding, and it keeps its position.
- R11: A pulse on `ctrlReset` stops the stream at the next edge. It clears the index, offset, `linkPos`, the alias and `bufComplete`, and sets `fifoReady`. A new rising edge of `ctrlRun` is needed to start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ctrlRun | input | 1 | Stream run bit |
| ctrlReset | input | 1 | Stream reset pulse |
| stsClear | input | 1 | Clears the buffer-complete bit |
| lastIdx | input | IDX_W | Index of the last valid list entry |
| listBase | input | ADDR_W | Base address of the descriptor list |
| posBufEn | input | 1 | Enables position-buffer writes |
| posBufBase | input | ADDR_W | Base address of the position buffer |
| descReqValid | output | 1 | Descriptor read request |
| descReqReady | input | 1 | Descriptor request accepted |
| descReqAddr | output | ADDR_W | Descriptor address |
| descRspValid | input | 1 | Descriptor data valid |
| descRspData | input | 128 | Descriptor contents |
| xferValid | input | 1 | Sample-side word request, held until done |
| xferDir | input | 1 | 1 reads memory, 0 writes memory |
| xferWdata | input | 32 | Word to write |
| xferDone | output | 1 | Word completed |
| xferErr | output | 1 | Request refused, stream stopped |
| xferRdata | output | 32 | Word read |
| memReq | output | 1 | Payload access request |
| memWe | output | 1 | Payload write enable |
| memAddr | output | ADDR_W | Payload address |
| memWdata | output | 32 | Payload write data |
| memAck | input | 1 | Payload access complete |
| memRdata | input | 32 | Payload read data |
| posWrEn | output | 1 | Position-buffer write strobe |
| posWrAddr | output | ADDR_W | Position-buffer slot address |
| posWrData | output | 32 | Position written |
| linkPos | output | 32 | Link position |
| linkPosAlias | output | 32 | Alias copy of the link position |
| bufComplete | output | 1 | Buffer-complete status |
| fifoReady | output | 1 | FIFO-ready status, set by stream reset |
| running | output | 1 | Stream active |

## Verification
`xferErr` is combinational, so the bench samples it a moment after raising `xferValid`. `xferDone` is high for the one cycle in which `memAck` is seen. The bench watches for it at falling edges and drops the request there. Position, offset, completion and the position-buffer strobe all change on the edge that consumes `memAck`, so the bench checks them at the falling edge after that. Start, stop and stream-reset effects likewise appear one edge after the stimulus, and the bench samples them at the following falling edge, allowing for a descriptor fetch whose latency the bench sets itself.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = 32;
  localparam int LEN_W      = 32;
  localparam int DESC_BITS  = 128;
  localparam int DESC_BYTES = 16;
  localparam int SLOT_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_READY,
    ST_MOVE
  } walkState_t;

  typedef struct packed {
    logic clearPos;
    logic streamRst;
    logic loadDesc;
    logic stepWord;
  } walkStrobe_t;
endpackage

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
  import sdw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlRun,
  input  logic        ctrlReset,
  input  logic        descReqReady,
  input  logic        descRspValid,
  input  logic        xferValid,
  input  logic        memAck,
  input  logic        entryEnd,
  output walkStrobe_t strobe,
  output logic        running,
  output logic        descReqValid,
  output logic        memReq,
  output logic        xferDone,
  output logic        xferErr
);
  walkState_t state, nextState;
  logic runQ;
  logic startEdge;

  assign startEdge = ctrlRun & ~runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      runQ  <= 1'b0;
    end else begin
      state <= nextState;
      runQ  <= ctrlRun;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (ctrlReset) begin
      strobe.streamRst = 1'b1;
      nextState        = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startEdge) begin
            strobe.clearPos = 1'b1;
            nextState       = ST_FETCH_REQ;
          end
        end
        ST_FETCH_REQ: begin
          if (!ctrlRun)          nextState = ST_IDLE;
          else if (descReqReady) nextState = ST_FETCH_WAIT;
        end
        ST_FETCH_WAIT: begin
          if (descRspValid) begin
            strobe.loadDesc = 1'b1;
            nextState       = ST_READY;
          end
        end
        ST_READY: begin
          if (!ctrlRun)       nextState = ST_IDLE;
          else if (xferValid) nextState = ST_MOVE;
        end
        ST_MOVE: begin
          if (memAck) begin
            strobe.stepWord = 1'b1;
            nextState       = entryEnd ? ST_FETCH_REQ : ST_READY;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign running      = (state != ST_IDLE);
  assign descReqValid = (state == ST_FETCH_REQ) && ctrlRun && !ctrlReset;
  assign memReq       = (state == ST_MOVE);
  assign xferDone     = (state == ST_MOVE) && memAck;
  assign xferErr      = xferValid && (state == ST_IDLE);

  // R9: a refused request never turns into a memory access on the next cycle
  assert_refuse_no_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !running && !startEdge) |=> !memReq);

  // R3: a word ends either done or refused, never both
  assert_single_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferDone, xferErr}));

  // R11: stream reset stops the walker at the next edge
  assert_reset_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |=> !running);

  // R4: the end of an entry leads to a fresh descriptor fetch
  assert_fetch_after_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && entryEnd && !ctrlReset) |=> (state == ST_FETCH_REQ));
endmodule

// File: rtl/sdw_datapath.sv
module sdw_datapath
  import sdw_pkg::*;
#(
  parameter  int ADDR_W      = 64,
  parameter  int MAX_ENTRIES = 256,
  parameter  int STREAM_SLOT = 0,
  localparam int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          strobe,
  input  logic                 stsClear,
  input  logic                 posBufEn,
  input  logic [IDX_W-1:0]     lastIdx,
  input  logic [ADDR_W-1:0]    listBase,
  input  logic [ADDR_W-1:0]    posBufBase,
  input  logic [DESC_BITS-1:0] descRspData,
  output logic                 entryEnd,
  output logic [ADDR_W-1:0]    descReqAddr,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 posWrEn,
  output logic [ADDR_W-1:0]    posWrAddr,
  output logic [LEN_W-1:0]     posWrData,
  output logic [LEN_W-1:0]     linkPos,
  output logic [LEN_W-1:0]     linkPosAlias,
  output logic                 bufComplete,
  output logic                 fifoReady
);
  localparam int                DESC_SH  = $clog2(DESC_BYTES);
  localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(STREAM_SLOT * SLOT_BYTES);
  localparam logic [LEN_W-1:0]  STEP     = LEN_W'(WORD_BYTES);

  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  offset;
  logic [LEN_W-1:0]  descLen;
  logic [ADDR_W-1:0] descAddr;
  logic              descIoc;
  logic [LEN_W-1:0]  nextOff;
  logic [LEN_W-1:0]  stepPos;
  logic              listEnd;
  logic              setComplete;
  logic              unusedRsvd;

  assign unusedRsvd = ^descRspData[DESC_BITS-1:97];

  assign nextOff     = offset + STEP;
  assign entryEnd    = (nextOff == descLen);
  assign listEnd     = (idx == lastIdx);
  assign stepPos     = (entryEnd && listEnd) ? '0 : (linkPos + STEP);
  assign setComplete = strobe.stepWord && entryEnd && descIoc;

  assign descReqAddr = listBase + (ADDR_W'(idx) << DESC_SH);
  assign memAddr     = descAddr + ADDR_W'(offset);
  assign posWrAddr   = posBufBase + SLOT_OFS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx          <= '0;
      offset       <= '0;
      descLen      <= '0;
      descAddr     <= '0;
      descIoc      <= 1'b0;
      linkPos      <= '0;
      linkPosAlias <= '0;
      bufComplete  <= 1'b0;
      fifoReady    <= 1'b0;
      posWrEn      <= 1'b0;
      posWrData    <= '0;
    end else if (strobe.streamRst) begin
      idx          <= '0;
      offset       <= '0;
      descLen      <= '0;
      descAddr     <= '0;
      descIoc      <= 1'b0;
      linkPos      <= '0;
      linkPosAlias <= '0;
      bufComplete  <= 1'b0;
      fifoReady    <= 1'b1;
      posWrEn      <= 1'b0;
      posWrData    <= '0;
    end else begin
      posWrEn     <= 1'b0;
      bufComplete <= (bufComplete && !stsClear) || setComplete;
      if (strobe.clearPos) begin
        idx          <= '0;
        offset       <= '0;
        linkPos      <= '0;
        linkPosAlias <= '0;
        posWrEn      <= posBufEn;
        posWrData    <= '0;
      end
      if (strobe.loadDesc) begin
        descAddr <= ADDR_W'(descRspData[63:0]);
        descLen  <= descRspData[95:64];
        descIoc  <= descRspData[96];
      end
      if (strobe.stepWord) begin
        linkPos      <= stepPos;
        linkPosAlias <= stepPos;
        posWrEn      <= posBufEn;
        posWrData    <= stepPos;
        if (entryEnd) begin
          offset <= '0;
          idx    <= listEnd ? '0 : idx + 1'b1;
        end else begin
          offset <= nextOff;
        end
      end
    end
  end

  // R2: a start leaves the position, index and offset at zero
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPos |=> (linkPos == '0 && idx == '0 && offset == '0));

  // R3: a word inside an entry moves the link position by one word
  assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepWord && !(entryEnd && listEnd)) |=> (linkPos == $past(linkPos) + STEP));

  // R3: the offset stays word aligned
  assert_offset_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    offset[1:0] == 2'b00);

  // R4: a descriptor is loaded only for an index inside the list
  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDesc |-> (idx <= lastIdx));

  // R5: finishing the last entry wraps the index and the position
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepWord && entryEnd && listEnd) |=> (linkPos == '0 && idx == '0));

  // R6: the completion bit holds until cleared or reset
  assert_complete_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bufComplete && !stsClear && !strobe.streamRst) |=> bufComplete);

  // R8: position writes only happen while the buffer is enabled
  assert_posbuf_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    posWrEn |-> $past(posBufEn));
endmodule

// File: rtl/stream_desc_walker.sv
module stream_desc_walker
  import sdw_pkg::*;
#(
  parameter  int ADDR_W      = 64,
  parameter  int MAX_ENTRIES = 256,
  parameter  int STREAM_SLOT = 0,
  localparam int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlRun,
  input  logic              ctrlReset,
  input  logic              stsClear,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              posBufEn,
  input  logic [ADDR_W-1:0] posBufBase,
  output logic              descReqValid,
  input  logic              descReqReady,
  output logic [ADDR_W-1:0] descReqAddr,
  input  logic              descRspValid,
  input  logic [127:0]      descRspData,
  input  logic              xferValid,
  input  logic              xferDir,
  input  logic [31:0]       xferWdata,
  output logic              xferDone,
  output logic              xferErr,
  output logic [31:0]       xferRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              posWrEn,
  output logic [ADDR_W-1:0] posWrAddr,
  output logic [31:0]       posWrData,
  output logic [31:0]       linkPos,
  output logic [31:0]       linkPosAlias,
  output logic              bufComplete,
  output logic              fifoReady,
  output logic              running
);
  walkStrobe_t strobe;
  logic        entryEnd;

  sdw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlRun      (ctrlRun),
    .ctrlReset    (ctrlReset),
    .descReqReady (descReqReady),
    .descRspValid (descRspValid),
    .xferValid    (xferValid),
    .memAck       (memAck),
    .entryEnd     (entryEnd),
    .strobe       (strobe),
    .running      (running),
    .descReqValid (descReqValid),
    .memReq       (memReq),
    .xferDone     (xferDone),
    .xferErr      (xferErr)
  );

  sdw_datapath #(
    .ADDR_W      (ADDR_W),
    .MAX_ENTRIES (MAX_ENTRIES),
    .STREAM_SLOT (STREAM_SLOT)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .stsClear     (stsClear),
    .posBufEn     (posBufEn),
    .lastIdx      (lastIdx),
    .listBase     (listBase),
    .posBufBase   (posBufBase),
    .descRspData  (descRspData),
    .entryEnd     (entryEnd),
    .descReqAddr  (descReqAddr),
    .memAddr      (memAddr),
    .posWrEn      (posWrEn),
    .posWrAddr    (posWrAddr),
    .posWrData    (posWrData),
    .linkPos      (linkPos),
    .linkPosAlias (linkPosAlias),
    .bufComplete  (bufComplete),
    .fifoReady    (fifoReady)
  );

  assign memWe     = ~xferDir;
  assign memWdata  = xferWdata;
  assign xferRdata = memRdata;
endmodule

// File: tb/stream_desc_walker_bench.sv
module stream_desc_walker_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 64;
  localparam int MAX_ENTRIES = 4;
  localparam int IDX_W       = 2;
  localparam int STREAM_SLOT = 3;
  localparam int DESC_LAT    = 3;
  localparam int WATCHDOG    = 100000;
  localparam logic [63:0] LIST_BASE = 64'h0000_0002_0000_0100;
  localparam logic [63:0] POS_BASE  = 64'h0000_0003_0000_0040;
  localparam logic [31:0] PAY_HI    = 32'h0000_0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlRun = 1'b0, ctrlReset = 1'b0, stsClear = 1'b0;
  logic [IDX_W-1:0] lastIdx = '0;
  logic posBufEn = 1'b0;
  logic descReqValid, descReqReady, descRspValid;
  logic [ADDR_W-1:0] descReqAddr;
  logic [127:0] descRspData;
  logic xferValid = 1'b0, xferDir = 1'b0;
  logic [31:0] xferWdata = '0;
  logic xferDone, xferErr;
  logic [31:0] xferRdata;
  logic memReq, memWe, memAck;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic posWrEn;
  logic [ADDR_W-1:0] posWrAddr;
  logic [31:0] posWrData, linkPos, linkPosAlias;
  logic bufComplete, fifoReady, running;

  int checks = 0, fails = 0, cyc = 0;
  int dLen [4];
  bit dIoc [4];
  int expIdx = 0, expOff = 0, expPos = 0, expFetch = 0;
  bit expComplete = 0;
  logic [31:0] pmem [64];
  logic [31:0] shadow [64];
  int dCnt, fetchCnt, fetchErr, addrErr;
  logic [1:0] dSel;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign descReqReady = 1'b1;

  stream_desc_walker #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES), .STREAM_SLOT(STREAM_SLOT))
  u_stream_desc_walker (
    .clk(clk), .rstN(rstN), .ctrlRun(ctrlRun), .ctrlReset(ctrlReset), .stsClear(stsClear),
    .lastIdx(lastIdx), .listBase(LIST_BASE), .posBufEn(posBufEn), .posBufBase(POS_BASE),
    .descReqValid(descReqValid), .descReqReady(descReqReady), .descReqAddr(descReqAddr),
    .descRspValid(descRspValid), .descRspData(descRspData),
    .xferValid(xferValid), .xferDir(xferDir), .xferWdata(xferWdata), .xferDone(xferDone),
    .xferErr(xferErr), .xferRdata(xferRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .posWrEn(posWrEn), .posWrAddr(posWrAddr), .posWrData(posWrData),
    .linkPos(linkPos), .linkPosAlias(linkPosAlias), .bufComplete(bufComplete),
    .fifoReady(fifoReady), .running(running)
  );

  function automatic logic [127:0] mkDesc(input int s);
    return {31'b0, dIoc[s], 32'(dLen[s]), PAY_HI, 32'(s * 64)};
  endfunction

  // descriptor memory with fixed response latency
  always @(posedge clk) begin
    if (!rstN) begin
      dCnt <= 0; descRspValid <= 1'b0; descRspData <= '0;
      fetchCnt <= 0; fetchErr <= 0; dSel <= '0;
    end else begin
      descRspValid <= 1'b0;
      if (dCnt != 0) begin
        dCnt <= dCnt - 1;
        if (dCnt == 1) begin
          descRspValid <= 1'b1;
          descRspData  <= mkDesc(int'(dSel));
        end
      end else if (descReqValid) begin
        dCnt     <= DESC_LAT;
        fetchCnt <= fetchCnt + 1;
        if (descReqAddr != LIST_BASE + 64'(expIdx) * 64'd16) fetchErr <= fetchErr + 1;
        dSel <= 2'((descReqAddr - LIST_BASE) >> 4);
      end
    end
  end

  // payload memory, one cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memRdata <= '0; addrErr <= 0;
      for (int i = 0; i < 64; i++) pmem[i] <= 32'hC0DE_0000 + 32'(i);
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        memAck   <= 1'b1;
        memRdata <= pmem[memAddr[7:2]];
        if (memWe) pmem[memAddr[7:2]] <= memWdata;
        if (memAddr[63:32] != PAY_HI || memAddr[31:8] != 24'd0 || memAddr[1:0] != 2'd0)
          addrErr <= addrErr + 1;
      end
    end
  end

  task automatic checkEq(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic setTable(input int c);
    for (int k = 0; k < 4; k++) begin
      dLen[k] = 4 * (1 + ((k + c) % 3));
      dIoc[k] = ((k + c) % 2) == 1;
    end
  endtask

  task automatic doWord(input bit dir, input logic [31:0] data, input int lastI);
    int wi;
    int to;
    logic [31:0] got;
    string posReq;
    wi = expIdx * 16 + expOff / 4;
    @(negedge clk);
    xferValid = 1'b1; xferDir = dir; xferWdata = data;
    to = 0;
    do begin
      @(negedge clk);
      to++;
    end while (!xferDone && to < 100);
    got = xferRdata;
    xferValid = 1'b0;
    checkEq("R3", "word handshake completes", 64'(to < 100), 64'd1);
    @(negedge clk);
    if (dir) checkEq("R3", "read word", 64'(got), 64'(shadow[wi]));
    else begin
      shadow[wi] = data;
      checkEq("R3", "written word", 64'(pmem[wi]), 64'(data));
    end
    posReq = "R3";
    expPos += 4; expOff += 4;
    if (expOff == dLen[expIdx]) begin
      expOff = 0;
      if (dIoc[expIdx]) expComplete = 1;
      expFetch++;
      if (expIdx == lastI) begin expIdx = 0; expPos = 0; posReq = "R5"; end
      else expIdx++;
    end
    checkEq(posReq, "link position", 64'(linkPos), 64'(expPos));
    checkEq("R7", "alias position", 64'(linkPosAlias), 64'(expPos));
    checkEq("R6", "buffer complete", 64'(bufComplete), 64'(expComplete));
    checkEq("R8", "position write strobe", 64'(posWrEn), 64'(posBufEn));
    if (posBufEn) begin
      checkEq("R8", "position slot address", posWrAddr, POS_BASE + 64'(STREAM_SLOT * 8));
      checkEq("R8", "position write data", 64'(posWrData), 64'(expPos));
    end
  endtask

  task automatic startStream();
    expIdx = 0; expOff = 0; expPos = 0; expComplete = 0;
    @(negedge clk);
    ctrlRun = 1'b1;
    @(negedge clk);
    checkEq("R2", "running after start", 64'(running), 64'd1);
    checkEq("R2", "position after start", 64'(linkPos), 64'd0);
    checkEq("R8", "start position write", 64'(posWrEn), 64'(posBufEn));
  endtask

  task automatic scenario(input int lastI);
    int sumLen;
    int nWords;
    int base;
    setTable(lastI);
    lastIdx = IDX_W'(lastI);
    posBufEn = (lastI % 2) == 0;
    sumLen = 0;
    for (int k = 0; k <= lastI; k++) sumLen += dLen[k];
    nWords = 2 * sumLen / 4 + 1;
    base = fetchCnt;
    expFetch = 1;
    startStream();
    for (int w = 0; w < nWords; w++)
      doWord(w[0], 32'h5A00_0000 ^ (32'(lastI) << 16) ^ 32'(w), lastI);
    repeat (DESC_LAT + 6) @(negedge clk);
    checkEq("R4", "descriptor fetch count", 64'(fetchCnt - base), 64'(expFetch));
    checkEq("R2", "descriptor fetch addresses", 64'(fetchErr), 64'd0);
    checkEq("R3", "payload address range", 64'(addrErr), 64'd0);
    ctrlRun = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R10", "stopped after run falls", 64'(running), 64'd0);
    checkEq("R10", "position kept after stop", 64'(linkPos), 64'(expPos));
    xferValid = 1'b1;
    #1;
    checkEq("R9", "refusal error", 64'(xferErr), 64'd1);
    checkEq("R9", "no memory access when stopped", 64'(memReq), 64'd0);
    @(negedge clk);
    xferValid = 1'b0;
    @(negedge clk);
    checkEq("R9", "position unchanged by refusal", 64'(linkPos), 64'(expPos));
    stsClear = 1'b1;
    @(negedge clk);
    stsClear = 1'b0;
    checkEq("R6", "complete cleared", 64'(bufComplete), 64'd0);
    expComplete = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "running at reset", 64'(running), 64'd0);
    checkEq("R1", "position at reset", 64'(linkPos), 64'd0);
    checkEq("R1", "alias at reset", 64'(linkPosAlias), 64'd0);
    checkEq("R1", "complete at reset", 64'(bufComplete), 64'd0);
    checkEq("R1", "fifo ready at reset", 64'(fifoReady), 64'd0);
    checkEq("R1", "no requests at reset", 64'({descReqValid, memReq, posWrEn}), 64'd0);

    for (int lastI = 0; lastI < 4; lastI++) scenario(lastI);

    // stream reset in the middle of a list
    setTable(1);
    lastIdx = IDX_W'(1);
    posBufEn = 1'b1;
    repeat (DESC_LAT + 4) @(negedge clk);
    startStream();
    for (int w = 0; w < 3; w++) doWord(1'b0, 32'h7E00_0000 + 32'(w), 1);
    checkEq("R6", "complete set before reset", 64'(bufComplete), 64'd1);
    ctrlReset = 1'b1;
    @(negedge clk);
    ctrlReset = 1'b0;
    checkEq("R11", "stopped by stream reset", 64'(running), 64'd0);
    checkEq("R11", "position cleared", 64'(linkPos), 64'd0);
    checkEq("R11", "alias cleared", 64'(linkPosAlias), 64'd0);
    checkEq("R11", "complete cleared", 64'(bufComplete), 64'd0);
    checkEq("R11", "fifo ready set", 64'(fifoReady), 64'd1);
    repeat (DESC_LAT + 4) @(negedge clk);
    checkEq("R11", "no restart without new edge", 64'(running), 64'd0);
    xferValid = 1'b1;
    #1;
    checkEq("R11", "request refused after reset", 64'(xferErr), 64'd1);
    @(negedge clk);
    xferValid = 1'b0;
    ctrlRun = 1'b0;
    expIdx = 0; expOff = 0; expPos = 0; expComplete = 0;
    startStream();
    doWord(1'b1, 32'h0, 1);
    checkEq("R11", "restart begins at entry 0", 64'(linkPos), 64'd4);
    ctrlRun = 1'b0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule